// File: doc/BRIEF.md
# Burst-Priority Codeword Interleaver

This block reorders one 736-bit codeword before it goes out as a series of short radio bursts. Bits 184 to 367 form the first chunk of the staircase redundancy and are the priority group. They are dealt out two per burst, and each pair opens its burst. That way every burst gives a receiver a little of the step-structured redundancy early, so it can start decoding before the whole packet has arrived and then refine the result over several passes.

The other 552 bits are the systematic part and the two later redundancy chunks. They are joined into one block, put through a fixed pseudo-random permutation taken from a skipping LFSR, and placed after the pair of each burst, 24 at a time. The codeword is loaded one bit per handshake into an internal buffer. It is then streamed out one bit per handshake, with the burst number, first-of-burst, last-of-burst and last-of-codeword flags alongside.

A second mode undoes the ordering. Bits that arrive in burst order are written to the codeword positions given by the same address sequence. They are then read out in natural order.

Top module: `hbi_interleaver`

## Requirements
- R1: After reset the block is in the load phase: `outValid` is 0 and `inReady` is 1.
- R2: In interleave mode the k-th accepted input bit is codeword index k. While a codeword is being emitted `inReady` stays 0. Once the handshake of the bit flagged `outLast` completes, `inReady` returns to 1.
- R3: Burst b, for b from 0 to 91, opens with codeword bits 184+2b and then 185+2b, and its burst-start flag is set on the first of them.
- R4: The scrambled block holds codeword indices 0..183 at block positions 0..183 and indices 368..735 at positions 184..551. A 10-bit LFSR is seeded to 1 at the start of every codeword. It steps as s' = {s[8:0], s[9]^s[6]}. Each state s from 1 to 552, taken in the order the states occur, selects block position s-1. States above 552 are skipped. The j-th selected position is the j-th scrambled bit.
- R5: Bursts 0..22 each carry 24 scrambled bits, 24b to 24b+23, after their pair, for 26 bits per burst. Bursts 23..91 carry only their pair.
- R6: `outBurst` gives the burst number of every emitted bit. `outBurstStart` marks the first bit of a burst, `outBurstEnd` marks its last bit, and `outLast` marks the 736th bit, which also ends burst 91.
- R7: Over one codeword every index 0..735 is emitted exactly once.
- R8: While `outValid` is 1 and `outReady` is 0, the bit and all flags on the output hold unchanged until the handshake.
- R9: In deinterleave mode the k-th accepted input bit is written to the codeword index that interleaving emits at position k. Output is then given in natural index order with `outBurst`, `outBurstStart` and `outBurstEnd` all 0, and `outLast` set on index 735.
- R10: `modeDeint` (1 = deinterleave) is sampled only with the first accepted input bit of a codeword. Changes to it later in that load or during emission have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeDeint | input | 1 | 1 selects deinterleave, sampled with the first input bit |
| inValid | input | 1 | Input bit is offered |
| inBit | input | 1 | Input bit value |
| inReady | output | 1 | Block accepts an input bit |
| outValid | output | 1 | Output bit is offered |
| outReady | input | 1 | Consumer accepts the output bit |
| outBit | output | 1 | Output bit value |
| outBurst | output | 7 | Burst number of the output bit |
| outBurstStart | output | 1 | First bit of a burst |
| outBurstEnd | output | 1 | Last bit of a burst |
| outLast | output | 1 | Last bit of the codeword |

## Verification
The assertions assume that a codeword is always loaded in full before the next emission is expected, and that `outReady` can change freely from cycle to cycle. They also assume that `modeDeint` carries meaning only when the first bit is accepted. The stimulus always pushes all 736 bits and waits on `inReady`, including the stall cycles of the deinterleave load while the LFSR skips states. `outReady` is driven randomly in some passes and `modeDeint` is toggled on alternate bits during loads. Both behaviours therefore stay within what the properties expect while still being exercised.

// File: rtl/hbi_pkg.sv
package hbi_pkg;
  parameter int CW_LEN    = 736;
  parameter int PRIO_BASE = 184;
  parameter int PRIO_LEN  = 184;
  parameter int PAIR_LEN  = 2;
  parameter int FILL_LEN  = 24;
  parameter int LFSR_W    = 10;
  parameter int LFSR_SEED = 1;
  parameter int LFSR_TAPS = 'h240;

  localparam int SCR_LEN     = CW_LEN - PRIO_LEN;
  localparam int ADDR_W      = $clog2(CW_LEN);
  localparam int PRIO_BURSTS = (PRIO_LEN + PAIR_LEN - 1) / PAIR_LEN;
  localparam int FILL_BURSTS = (SCR_LEN + FILL_LEN - 1) / FILL_LEN;
  localparam int NUM_BURSTS  = (PRIO_BURSTS > FILL_BURSTS) ? PRIO_BURSTS : FILL_BURSTS;
  localparam int BURST_W     = $clog2(NUM_BURSTS);

  typedef logic [ADDR_W-1:0]  addr_t;
  typedef logic [BURST_W-1:0] burst_t;

  typedef enum logic {PH_LOAD = 1'b0, PH_EMIT = 1'b1} phase_t;

  // strobes from control to the codeword buffer
  typedef struct packed {
    logic  wrEn;
    addr_t wrAddr;
    addr_t rdAddr;
  } dpStrobe_t;

  // current element of the burst ordering
  typedef struct packed {
    logic   valid;
    addr_t  addr;
    burst_t burst;
    logic   first;
    logic   lastInBurst;
  } seqElem_t;
endpackage

// File: rtl/hbi_burst_seq.sv
module hbi_burst_seq
  import hbi_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     restart,
  input  logic     active,
  input  logic     step,
  output seqElem_t elem
);
  localparam int PRIO_CW = $clog2(PRIO_LEN + 1);
  localparam int SCR_CW  = $clog2(SCR_LEN + 1);
  localparam int PAIR_CW = $clog2(PAIR_LEN + 1);
  localparam int FILL_CW = $clog2(FILL_LEN + 1);

  logic [PRIO_CW-1:0] prioCnt;
  logic [SCR_CW-1:0]  scrCnt;
  logic [PAIR_CW-1:0] pairCnt;
  logic [FILL_CW-1:0] fillCnt;
  logic [LFSR_W-1:0]  lfsr;
  logic [LFSR_W-1:0]  scrPos;
  burst_t burstIdx;
  addr_t  fillAddr, prioAddr;
  logic   prioLeft, scrLeft, isPrio, isFill, inRange, lastElem;
  logic   lfsrStep, advance, fb;

  always_comb begin
    prioLeft = int'(prioCnt) < PRIO_LEN;
    scrLeft  = int'(scrCnt) < SCR_LEN;
    isPrio   = (int'(pairCnt) < PAIR_LEN) && prioLeft;
    isFill   = !isPrio && (int'(fillCnt) < FILL_LEN) && scrLeft;
    inRange  = (lfsr != '0) && (int'(lfsr) <= SCR_LEN);
    scrPos   = lfsr - LFSR_W'(1);
    // block positions past the priority base jump over the priority group
    fillAddr = (int'(scrPos) < PRIO_BASE) ? ADDR_W'(scrPos)
                                          : ADDR_W'(int'(scrPos) + PRIO_LEN);
    prioAddr = ADDR_W'(PRIO_BASE + int'(prioCnt));
    if (isPrio)
      lastElem = ((int'(pairCnt) + 1 == PAIR_LEN) || (int'(prioCnt) + 1 == PRIO_LEN))
                 && !scrLeft;
    else
      lastElem = (int'(fillCnt) + 1 == FILL_LEN) || (int'(scrCnt) + 1 == SCR_LEN);
    fb       = ^(lfsr & LFSR_W'(LFSR_TAPS));
    lfsrStep = active && isFill && (!inRange || step);

    elem.valid       = active && (isPrio || (isFill && inRange));
    elem.addr        = isPrio ? prioAddr : fillAddr;
    elem.burst       = burstIdx;
    elem.first       = (pairCnt == '0) && (fillCnt == '0);
    elem.lastInBurst = lastElem;
    advance          = step && elem.valid;
  end

  always_ff @(posedge clk) begin
    if (!rstN || restart) begin
      prioCnt  <= '0;
      scrCnt   <= '0;
      pairCnt  <= '0;
      fillCnt  <= '0;
      burstIdx <= '0;
      lfsr     <= LFSR_W'(LFSR_SEED);
    end else begin
      if (lfsrStep) lfsr <= {lfsr[LFSR_W-2:0], fb};
      if (advance) begin
        if (isPrio) prioCnt <= prioCnt + 1'b1;
        else        scrCnt  <= scrCnt + 1'b1;
        if (lastElem) begin
          burstIdx <= burstIdx + 1'b1;
          pairCnt  <= '0;
          fillCnt  <= '0;
        end else if (isPrio) begin
          pairCnt <= pairCnt + 1'b1;
        end else begin
          fillCnt <= fillCnt + 1'b1;
        end
      end
    end
  end

  assert_lfsr_live_R4: assert property (@(posedge clk) disable iff (!rstN)
    lfsr != '0);
  assert_prio_first_R3: assert property (@(posedge clk) disable iff (!rstN)
    (advance && isPrio) |-> (fillCnt == '0));
  assert_fill_budget_R5: assert property (@(posedge clk) disable iff (!rstN)
    (advance && isFill) |-> (int'(burstIdx) < FILL_BURSTS));
  assert_burst_bound_R5: assert property (@(posedge clk) disable iff (!rstN)
    elem.valid |-> (int'(elem.burst) < NUM_BURSTS));
endmodule

// File: rtl/hbi_ctrl.sv
module hbi_ctrl
  import hbi_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      modeDeint,
  input  logic      inValid,
  output logic      inReady,
  output logic      outValid,
  input  logic      outReady,
  output burst_t    outBurst,
  output logic      outBurstStart,
  output logic      outBurstEnd,
  output logic      outLast,
  output dpStrobe_t strobe
);
  phase_t   phase;
  logic     deintQ;
  addr_t    seqCnt;
  seqElem_t elem;
  logic     effDeint, useGen, inFire, outFire, lastCnt, seqRestart;

  hbi_burst_seq u_seq (
    .clk    (clk),
    .rstN   (rstN),
    .restart(seqRestart),
    .active (useGen),
    .step   (inFire || outFire),
    .elem   (elem)
  );

  always_comb begin
    lastCnt  = int'(seqCnt) == CW_LEN - 1;
    // mode is taken live only for the first bit of a load
    effDeint = (phase == PH_LOAD && seqCnt == '0) ? modeDeint : deintQ;
    useGen   = (phase == PH_LOAD) ? effDeint : !deintQ;
    inReady  = (phase == PH_LOAD) && (!effDeint || elem.valid);
    outValid = (phase == PH_EMIT) && (deintQ || elem.valid);
    inFire   = inValid && inReady;
    outFire  = outValid && outReady;
    seqRestart    = (inFire || outFire) && lastCnt;
    outBurst      = (outValid && !deintQ) ? elem.burst : '0;
    outBurstStart = outValid && !deintQ && elem.first;
    outBurstEnd   = outValid && !deintQ && elem.lastInBurst;
    outLast       = outValid && lastCnt;
    strobe.wrEn   = inFire;
    strobe.wrAddr = effDeint ? elem.addr : seqCnt;
    strobe.rdAddr = deintQ ? seqCnt : elem.addr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase  <= PH_LOAD;
      deintQ <= 1'b0;
      seqCnt <= '0;
    end else begin
      if (inFire && seqCnt == '0) deintQ <= modeDeint;
      if (inFire || outFire) begin
        if (lastCnt) begin
          seqCnt <= '0;
          phase  <= (phase == PH_LOAD) ? PH_EMIT : PH_LOAD;
        end else begin
          seqCnt <= seqCnt + 1'b1;
        end
      end
    end
  end

  assert_reload_R2: assert property (@(posedge clk) disable iff (!rstN)
    (outFire && outLast) |=> (inReady && !outValid));
  assert_hold_flags_R8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outBurst) && $stable(outBurstStart)
                                 && $stable(outBurstEnd) && $stable(outLast)));
  assert_last_closes_R6: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outLast && !deintQ) |-> outBurstEnd);
  assert_mode_kept_R10: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_EMIT) |-> $stable(deintQ));
endmodule

// File: rtl/hbi_dpath.sv
module hbi_dpath
  import hbi_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  dpStrobe_t strobe,
  input  logic      inBit,
  output logic      outBit
);
  logic [CW_LEN-1:0] cwBuf;

  always_ff @(posedge clk) begin
    if (!rstN)            cwBuf <= '0;
    else if (strobe.wrEn) cwBuf[strobe.wrAddr] <= inBit;
  end

  always_comb outBit = cwBuf[strobe.rdAddr];

  assert_addr_inside_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrEn |-> (int'(strobe.wrAddr) < CW_LEN));
endmodule

// File: rtl/hbi_interleaver.sv
module hbi_interleaver
  import hbi_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               modeDeint,
  input  logic               inValid,
  input  logic               inBit,
  output logic               inReady,
  output logic               outValid,
  input  logic               outReady,
  output logic               outBit,
  output logic [BURST_W-1:0] outBurst,
  output logic               outBurstStart,
  output logic               outBurstEnd,
  output logic               outLast
);
  dpStrobe_t strobe;

  hbi_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .modeDeint    (modeDeint),
    .inValid      (inValid),
    .inReady      (inReady),
    .outValid     (outValid),
    .outReady     (outReady),
    .outBurst     (outBurst),
    .outBurstStart(outBurstStart),
    .outBurstEnd  (outBurstEnd),
    .outLast      (outLast),
    .strobe       (strobe)
  );

  hbi_dpath u_dpath (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .inBit (inBit),
    .outBit(outBit)
  );

  assert_bit_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> $stable(outBit));
endmodule

// File: tb/sim_hbi_interleaver.sv
`timescale 1ns/1ps
module sim_hbi_interleaver;
  localparam int N = 736;
  localparam int NSCR = 552;

  logic clk = 1'b0, rstN = 1'b0, modeDeint = 1'b0, inValid = 1'b0, inBit = 1'b0, outReady = 1'b0;
  logic inReady, outValid, outBit, outBurstStart, outBurstEnd, outLast;
  logic [6:0] outBurst;

  int checks = 0, failures = 0;
  int expIdx[N];
  int expBurst[N];
  bit expStart[N], expEnd[N];
  bit cw[N], ldBits[N], gBit[N], gStart[N], gEnd[N], gLast[N];
  int gBurst[N];
  bit busyReadyErr;

  hbi_interleaver u0 (
    .clk(clk), .rstN(rstN), .modeDeint(modeDeint), .inValid(inValid), .inBit(inBit),
    .inReady(inReady), .outValid(outValid), .outReady(outReady), .outBit(outBit),
    .outBurst(outBurst), .outBurstStart(outBurstStart), .outBurstEnd(outBurstEnd),
    .outLast(outLast)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic buildModel();
    int scr[NSCR];
    int s = 1;
    int j = 0;
    int k = 0;
    while (j < NSCR) begin
      if (s <= NSCR) begin
        scr[j] = (s - 1 < 184) ? s - 1 : s - 1 + 184;
        j++;
      end
      s = ((s << 1) & 1023) | (((s >> 9) ^ (s >> 6)) & 1);
    end
    for (int b = 0; b < 92; b++) begin
      for (int i = 0; i < 2; i++) begin
        expIdx[k] = 184 + 2*b + i; expBurst[k] = b;
        expStart[k] = (i == 0); expEnd[k] = 1'b0; k++;
      end
      for (int f = 0; f < 24; f++) begin
        if (24*b + f < NSCR) begin
          expIdx[k] = scr[24*b + f]; expBurst[k] = b;
          expStart[k] = 1'b0; expEnd[k] = 1'b0; k++;
        end
      end
      expEnd[k-1] = 1'b1;
    end
  endtask

  task automatic loadWord(input bit mode, input bit toggle);
    for (int k = 0; k < N; k++) begin
      inValid = 1'b1;
      inBit = ldBits[k];
      modeDeint = (k == 0 || !toggle) ? mode : (k[0] ? ~mode : mode);
      while (!inReady) @(negedge clk);
      @(negedge clk);
    end
    inValid = 1'b0;
  endtask

  task automatic drain(input bit randReady);
    int n = 0;
    busyReadyErr = 1'b0;
    while (n < N) begin
      outReady = randReady ? ($urandom % 3 != 0) : 1'b1;
      if (inReady) busyReadyErr = 1'b1;
      if (outValid && outReady) begin
        gBit[n] = outBit; gBurst[n] = int'(outBurst); gStart[n] = outBurstStart;
        gEnd[n] = outBurstEnd; gLast[n] = outLast; n++;
      end
      @(negedge clk);
    end
    outReady = 1'b0;
  endtask

  task automatic checkInterleave(output int mism);
    mism = 0;
    for (int n = 0; n < N; n++) begin
      bit okBit = (gBit[n] == cw[expIdx[n]]);
      if (!okBit || gBurst[n] != expBurst[n] || gStart[n] != expStart[n] ||
          gEnd[n] != expEnd[n] || gLast[n] != (n == N-1)) mism++;
      if (expIdx[n] >= 184 && expIdx[n] < 368)
        chk(okBit, $sformatf("R3 priority bit at position %0d", n), gBit[n], cw[expIdx[n]]);
      else
        chk(okBit, $sformatf("R4 scrambled bit at position %0d", n), gBit[n], cw[expIdx[n]]);
      chk(gBurst[n] == expBurst[n], $sformatf("R6 burst number at position %0d", n), gBurst[n], expBurst[n]);
      chk(gStart[n] == expStart[n], $sformatf("R6 start flag at position %0d", n), gStart[n], expStart[n]);
      chk(gEnd[n] == expEnd[n], $sformatf("R6 end flag at position %0d", n), gEnd[n], expEnd[n]);
      chk(gLast[n] == (n == N-1), $sformatf("R6 last flag at position %0d", n), gLast[n], n == N-1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int mism;
    int rec[N];
    int seen[N];
    int cnt0, cnt22, cnt23;
    buildModel();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(outValid == 1'b0, "R1 outValid after reset", outValid, 0);
    chk(inReady == 1'b1, "R1 inReady after reset", inReady, 1);

    // pass A: plain interleave
    for (int i = 0; i < N; i++) begin cw[i] = 1'($urandom); ldBits[i] = cw[i]; end
    loadWord(1'b0, 1'b0);
    drain(1'b0);
    checkInterleave(mism);
    chk(!busyReadyErr, "R2 inReady low during emission", busyReadyErr, 0);
    chk(inReady == 1'b1, "R2 inReady back after last bit", inReady, 1);
    cnt0 = 0; cnt22 = 0; cnt23 = 0;
    for (int n = 0; n < N; n++) begin
      if (gBurst[n] == 0) cnt0++;
      if (gBurst[n] == 22) cnt22++;
      if (gBurst[n] == 23) cnt23++;
    end
    chk(cnt0 == 26, "R5 bits in burst 0", cnt0, 26);
    chk(cnt22 == 26, "R5 bits in burst 22", cnt22, 26);
    chk(cnt23 == 2, "R5 bits in burst 23", cnt23, 2);

    // address recovery, one index bit per pass
    for (int n = 0; n < N; n++) begin rec[n] = 0; seen[n] = 0; end
    for (int b = 0; b < 10; b++) begin
      for (int i = 0; i < N; i++) ldBits[i] = 1'((i >> b) & 1);
      loadWord(1'b0, 1'b0);
      drain(1'b0);
      for (int n = 0; n < N; n++) rec[n] |= int'(gBit[n]) << b;
    end
    for (int n = 0; n < N; n++) begin
      if (rec[n] < N) seen[rec[n]]++;
      chk(rec[n] == expIdx[n], $sformatf("R4 source index at position %0d", n), rec[n], expIdx[n]);
    end
    for (int i = 0; i < N; i++)
      chk(seen[i] == 1, $sformatf("R7 times index %0d emitted", i), seen[i], 1);

    // pass B: backpressure and mode toggling during load
    for (int i = 0; i < N; i++) begin cw[i] = 1'($urandom); ldBits[i] = cw[i]; end
    loadWord(1'b0, 1'b1);
    drain(1'b1);
    checkInterleave(mism);
    chk(mism == 0, "R8 stream intact under random outReady", mism, 0);
    chk(mism == 0, "R10 mode toggles after first bit ignored", mism, 0);
    chk(!busyReadyErr, "R2 inReady low during emission with stalls", busyReadyErr, 0);

    // pass C: deinterleave restores natural order
    for (int i = 0; i < N; i++) cw[i] = 1'($urandom);
    for (int k = 0; k < N; k++) ldBits[k] = cw[expIdx[k]];
    loadWord(1'b1, 1'b1);
    drain(1'b1);
    for (int n = 0; n < N; n++) begin
      chk(gBit[n] == cw[n], $sformatf("R9 restored bit %0d", n), gBit[n], cw[n]);
      chk(gBurst[n] == 0 && !gStart[n] && !gEnd[n], $sformatf("R9 burst fields zero at %0d", n),
          gBurst[n] + 2*int'(gStart[n]) + 4*int'(gEnd[n]), 0);
      chk(gLast[n] == (n == N-1), $sformatf("R9 last flag at %0d", n), gLast[n], n == N-1);
    end
    chk(inReady == 1'b1, "R2 inReady back after deinterleave", inReady, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule